// File: doc/BRIEF.md
# Clamping Signed Adder

This block adds two two's-complement operands of a configurable width and registers the sum. If the true sum does not fit in the operand width, the block does not wrap. It clamps the result to the largest positive code or to the most negative code, as a DSP arithmetic unit does. A flag travels with each result and marks the results that were clamped.

Overflow is found without widening the adder. The bits below the sign position are added as an unsigned sum, and the carry out of that sum is kept apart. That carry is compared with the two operand sign bits. When the two signs differ, the sum always fits. When both signs are set and no carry reaches the sign position, the true sum lies below the range. When both signs are clear and a carry does reach the sign position, the true sum lies above the range.

An optional symmetric mode keeps the output range balanced around zero. It adds a second register stage, which turns any most-negative code coming out of the first stage into that code plus one.

Top module: `sadd_clamp`

## Requirements
- R1: If the true sum of `op_a` and `op_b`, both read as signed WIDTH-bit values, fits in WIDTH bits, `sum_q` equals that sum. In symmetric mode this holds except when the sum is the most negative code (see R6).
- R2: If two non-negative operands overflow, `sum_q` is 0 followed by WIDTH-1 ones (the largest positive code) and `sat_q` is 1.
- R3: If two negative operands overflow and SYMMETRIC=0, `sum_q` is 1 followed by WIDTH-1 zeros (the most negative code) and `sat_q` is 1.
- R4: With SYMMETRIC=0, operands whose sign bits (bit WIDTH-1) differ never set `sat_q`.
- R5: A result appears with `out_valid` high exactly 1 clock edge after its `in_valid` sample when SYMMETRIC=0, and exactly 2 edges after it when SYMMETRIC=1. There is one result per accepted operand pair, in the order the pairs were accepted.
- R6: With SYMMETRIC=1, the code 1 followed by WIDTH-1 zeros never appears on `sum_q` while `out_valid` is high. A result that would be that code, whether it came from a clamp or from an exact sum, is output as that code plus one, with `sat_q`=1.
- R7: While `rst` is high at a clock edge, `sum_q`, `sat_q` and `out_valid` become 0.
- R8: `sat_q` is 0 for every result that was not clamped or corrected.
- R9: On an edge where no valid data reaches the output register, `sum_q` and `sat_q` keep their previous values and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The operand pair is valid this cycle |
| op_a | input | WIDTH | First operand, two's complement |
| op_b | input | WIDTH | Second operand, two's complement |
| sum_q | output | WIDTH | Registered clamped sum |
| sat_q | output | 1 | The result was clamped or corrected |
| out_valid | output | 1 | `sum_q` and `sat_q` hold a new result |

## Verification
The assertions assume that `op_a` and `op_b` are known, driven values on every edge where `in_valid` is high. They also assume that `in_valid` is low or ignored while `rst` is high. Pipeline checks start only after as many cycles since reset as the latency, so that bubbles inserted before the first result cannot confuse them.

The stimulus changes inputs only on the falling clock edge and holds `in_valid` at a defined level at all times. It walks every operand pair at WIDTH=8, with idle cycles inserted at regular intervals, so that both the back-to-back path and the hold behaviour are exercised in both modes.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_POS  = 2'd1,
    CLAMP_NEG  = 2'd2
  } clamp_e;

  // Decide the clamp direction from the operand signs and the carry that
  // reaches the sign position from the lower partial sum.
  function automatic clamp_e clamp_kind(input logic sa, input logic sb, input logic cin);
    if (sa && sb && !cin)  return CLAMP_NEG;
    if (!sa && !sb && cin) return CLAMP_POS;
    return CLAMP_NONE;
  endfunction

  // Sign bit of a sum that did not overflow.
  function automatic logic fit_sign(input logic sa, input logic sb, input logic cin);
    return (sa & sb) | ((sa ^ sb) & ~cin);
  endfunction

endpackage

// File: rtl/sadd_lowsum.sv
module sadd_lowsum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-2:0] low,
  output logic             carry_to_sign
);
  localparam int LW = WIDTH - 1;

  logic [LW:0] partial;

  always_comb begin
    partial = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
  end

  assign low           = partial[LW-1:0];
  assign carry_to_sign = partial[LW];
endmodule

// File: rtl/sadd_select.sv
module sadd_select
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic             carry_to_sign,
  input  logic [WIDTH-2:0] low,
  output logic [WIDTH-1:0] result,
  output logic             sat,
  output logic             ovf_pos,
  output logic             ovf_neg
);
  localparam int LW = WIDTH - 1;

  clamp_e kind;

  always_comb begin
    kind = clamp_kind(sign_a, sign_b, carry_to_sign);
    unique case (kind)
      CLAMP_POS: result = {1'b0, {LW{1'b1}}};
      CLAMP_NEG: result = {1'b1, {LW{1'b0}}};
      default:   result = {fit_sign(sign_a, sign_b, carry_to_sign), low};
    endcase
  end

  assign sat     = (kind != CLAMP_NONE);
  assign ovf_pos = (kind == CLAMP_POS);
  assign ovf_neg = (kind == CLAMP_NEG);
endmodule

// File: rtl/sadd_symfix.sv
module sadd_symfix #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_sum,
  input  logic             in_sat,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_sat,
  output logic             out_valid,
  output logic             fix_hit
);
  localparam int LW = WIDTH - 1;
  localparam logic [WIDTH-1:0] MIN_CODE = {1'b1, {LW{1'b0}}};

  assign fix_hit = in_valid && (in_sum == MIN_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sum   <= '0;
      out_sat   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum <= fix_hit ? (in_sum + {{LW{1'b0}}, 1'b1}) : in_sum;
        out_sat <= in_sat | fix_hit;
      end
    end
  end
endmodule

// File: rtl/sadd_clamp.sv
module sadd_clamp #(
  parameter int WIDTH     = 8,
  parameter bit SYMMETRIC = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum_q,
  output logic             sat_q,
  output logic             out_valid
);
  localparam int MSB = WIDTH - 1;

  // Named internal events, brought out for the checker.
  logic [WIDTH-2:0] low_sum;
  logic             carry_to_sign;
  logic [WIDTH-1:0] s0_result;
  logic             s0_sat;
  logic             ovf_pos;
  logic             ovf_neg;

  logic [WIDTH-1:0] s1_sum;
  logic             s1_sat;
  logic             s1_valid;

  sadd_lowsum #(.WIDTH(WIDTH)) u_lowsum (
    .a             (op_a),
    .b             (op_b),
    .low           (low_sum),
    .carry_to_sign (carry_to_sign)
  );

  sadd_select #(.WIDTH(WIDTH)) u_select (
    .sign_a        (op_a[MSB]),
    .sign_b        (op_b[MSB]),
    .carry_to_sign (carry_to_sign),
    .low           (low_sum),
    .result        (s0_result),
    .sat           (s0_sat),
    .ovf_pos       (ovf_pos),
    .ovf_neg       (ovf_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_sum   <= '0;
      s1_sat   <= 1'b0;
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sum <= s0_result;
        s1_sat <= s0_sat;
      end
    end
  end

  generate
    if (SYMMETRIC) begin : g_sym
      logic fix_hit;
      sadd_symfix #(.WIDTH(WIDTH)) u_symfix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_valid),
        .in_sum    (s1_sum),
        .in_sat    (s1_sat),
        .out_sum   (sum_q),
        .out_sat   (sat_q),
        .out_valid (out_valid),
        .fix_hit   (fix_hit)
      );
    end else begin : g_asym
      assign sum_q     = s1_sum;
      assign sat_q     = s1_sat;
      assign out_valid = s1_valid;
    end
  endgenerate
endmodule

// File: rtl/sadd_clamp_chk.sv
module sadd_clamp_chk #(
  parameter int WIDTH     = 8,
  parameter bit SYMMETRIC = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] sum_q,
  input logic             sat_q,
  input logic             out_valid,
  input logic             ovf_pos,
  input logic             ovf_neg
);
  localparam int LW  = WIDTH - 1;
  localparam int LAT = SYMMETRIC ? 2 : 1;
  localparam logic [WIDTH-1:0] MAX_CODE = {1'b0, {LW{1'b1}}};
  localparam logic [WIDTH-1:0] MIN_CODE = {1'b1, {LW{1'b0}}};
  localparam logic [WIDTH-1:0] NEG_LIM  = SYMMETRIC ? (MIN_CODE + 1'b1) : MIN_CODE;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_OVF_POS_SIGNS: assert property (@(posedge clk) disable iff (rst)
    ovf_pos |-> (!op_a[LW] && !op_b[LW])); // R2

  AST_OVF_NEG_SIGNS: assert property (@(posedge clk) disable iff (rst)
    ovf_neg |-> (op_a[LW] && op_b[LW])); // R3

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LAT) |-> (out_valid == $past(in_valid, LAT))); // R5

  AST_POS_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sat_q && !sum_q[LW]) |-> (sum_q == MAX_CODE)); // R2

  AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sat_q && sum_q[LW]) |-> (sum_q == NEG_LIM)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LAT && !$past(in_valid, LAT)) |-> ($stable(sum_q) && $stable(sat_q))); // R9

  generate
    if (SYMMETRIC) begin : g_sym_chk
      AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sum_q != MIN_CODE)); // R6
    end else begin : g_asym_chk
      AST_OPP_SIGN_NOSAT: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && $past(in_valid && (op_a[LW] ^ op_b[LW]))) |-> !sat_q); // R4
    end
  endgenerate
endmodule

bind sadd_clamp sadd_clamp_chk #(.WIDTH(WIDTH), .SYMMETRIC(SYMMETRIC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .sum_q     (sum_q),
  .sat_q     (sat_q),
  .out_valid (out_valid),
  .ovf_pos   (ovf_pos),
  .ovf_neg   (ovf_neg)
);

// File: tb/sadd_clamp_bench.sv
`timescale 1ns/1ps
module sadd_clamp_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;

  logic [W-1:0] sum_a, sum_s;
  logic         sat_a, sat_s, vld_a, vld_s;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [W:0] q_asym[$];
  logic [W:0] q_sym[$];

  always #2.5 clk = ~clk;

  sadd_clamp #(.WIDTH(W), .SYMMETRIC(1'b0)) u_sadd_clamp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sum_q(sum_a), .sat_q(sat_a), .out_valid(vld_a)
  );

  sadd_clamp #(.WIDTH(W), .SYMMETRIC(1'b1)) u_sadd_clamp_sym (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sum_q(sum_s), .sat_q(sat_s), .out_valid(vld_s)
  );

  // Reference: wide integer sum, then clamp; {sat, sum}.
  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sym);
    int s;
    int hi, lo;
    logic sat;
    hi = 127;
    lo = sym ? -127 : -128;
    s = int'($signed(a)) + int'($signed(b));
    sat = 1'b0;
    if (s > hi) begin s = hi; sat = 1'b1; end
    if (s < lo) begin s = lo; sat = 1'b1; end
    return {sat, s[W-1:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_pair(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; in_valid = 1'b1;
    q_asym.push_back(model(a, b, 1'b0));
    q_sym.push_back(model(a, b, 1'b1));
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: R1 R2 R3 R4 R6 R8 via model comparison.
  always @(posedge clk) begin
    #1;
    if (!rst && vld_a) begin
      if (q_asym.size() == 0) check("R5 asym unexpected result", 1, 0);
      else begin
        logic [W:0] e;
        e = q_asym.pop_front();
        check("R1/R2/R3/R4/R8 asym", {sat_a, sum_a}, e);
      end
    end
    if (!rst && vld_s) begin
      if (q_sym.size() == 0) check("R5 sym unexpected result", 1, 0);
      else begin
        logic [W:0] e;
        e = q_sym.pop_front();
        check("R1/R2/R6/R8 sym", {sat_s, sum_s}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    // R7: reset with junk on the inputs
    in_valid = 1'b1; op_a = 8'h7f; op_b = 8'h7f;
    repeat (3) @(negedge clk);
    check("R7 asym zeros", {vld_a, sat_a, sum_a}, 0);
    check("R7 sym zeros",  {vld_s, sat_s, sum_s}, 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5: latency per mode
    drive_pair(8'd3, 8'd4);
    in_valid = 1'b0;
    check("R5 asym valid after 1 edge", {vld_a, sum_a}, {1'b1, 8'd7});
    check("R5 sym not yet valid", vld_s, 0);
    @(negedge clk);
    check("R5 sym valid after 2 edges", {vld_s, sum_s}, {1'b1, 8'd7});
    check("R5 asym valid drops", vld_a, 0);
    repeat (3) @(negedge clk);

    // Directed corners: R2, R3, R6
    drive_pair(8'h7f, 8'h01);  // +128 -> 127 sat R2
    drive_pair(8'h80, 8'hff);  // -129 -> -128 / -127 R3 R6
    drive_pair(8'h80, 8'h00);  // exact -128, R6 correction
    drive_pair(8'h80, 8'h7f);  // opposite signs R4
    idle();

    // Exhaustive walk with regular bubbles
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        drive_pair(i[W-1:0], j[W-1:0]);
        if (((i * 256 + j) % 37) == 0) idle();
      end
    end
    idle();
    repeat (4) @(negedge clk);
    check("R5 asym all results seen", q_asym.size(), 0);
    check("R5 sym all results seen", q_sym.size(), 0);

    // R9: hold while idle
    drive_pair(8'd100, 8'd100);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    held = sum_a;
    check("R9 asym clamp value", {sat_a, held}, {1'b1, 8'h7f});
    repeat (3) @(negedge clk);
    check("R9 asym holds", {vld_a, sat_a, sum_a}, {1'b0, 1'b1, 8'h7f});
    check("R9 sym holds",  {vld_s, sat_s, sum_s}, {1'b0, 1'b1, 8'h7f});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule